// File: doc/BRIEF.md
# Source Operand Sign-Modifier Stage

This stage sits between operand fetch and a vector ALU and produces one source operand for every lane of a wide SIMD datapath. The operand either comes from a fetched vector register, with one element per lane, or from a single scalar value that is copied into every lane. Floating-point operands can then have their sign changed by two optional modifiers: absolute value and negate. Both modifiers work only on the sign bit. The element width is selected per operation as 32 or 64 bits.

The modifiers are defined only for floating-point operands. If a modifier is requested while the operand is flagged as integer, the stage raises an error flag and lets the data through without any sign change. The stage is combinational. A parameter can add one output register, and the default build includes it. There is no state machine: the only state is the optional output pipeline register, which is either holding a result or idle.

Top module: `opmod_stage`

## Requirements
- R1: With `scalar_sel` low and no modifier, lane i of `out_data` (bits 64*i+63 down to 64*i) equals lane i of `src_vec` in 64-bit mode.
- R2: With `scalar_sel` high, every lane carries the value taken from `src_scalar`, and `src_vec` has no effect on `out_data`.
- R3: `mod_abs` alone forces the sign bit of every lane to 0. The sign bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R4: `mod_neg` alone inverts the sign bit of every lane.
- R5: When `mod_abs` and `mod_neg` are both set, absolute value is applied first and negate second, so the sign bit of every lane is 1.
- R6: `elem_wide` = 0 selects 32-bit elements. In that mode the upper 32 bits of every output lane are 0, and bit 31 is the sign bit.
- R7: If `type_int` is high and either modifier is requested, `out_err` is 1 and the data passes through without any sign change.
- R8: `out_err` is 0 for any floating-point operand, and for an integer operand that requests no modifier.
- R9: With the output register enabled (the default), `out_valid`, `out_data` and `out_err` follow the inputs one clock later. An idle input cycle gives `out_valid` = 0, and reset clears `out_valid` and `out_err`.
- R10: Every bit other than the sign bit is preserved, so NaN payloads and mantissas pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| src_vec | input | LANES*64 | Fetched vector data, 64 bits per lane, lane 0 in the least significant bits |
| src_scalar | input | 64 | Scalar operand value |
| scalar_sel | input | 1 | 1: copy `src_scalar` into every lane |
| mod_abs | input | 1 | Absolute-value modifier request |
| mod_neg | input | 1 | Negate modifier request |
| elem_wide | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| type_int | input | 1 | Operand is an integer type |
| out_valid | output | 1 | Result valid |
| out_data | output | LANES*64 | Modified lane data |
| out_err | output | 1 | A modifier was requested on an integer operand |

## Verification
Each vector-mode test uses lanes with alternating sign bits. This shows whether abs, negate and the combined modifier act on every lane, and whether they act in the right order. The 32-bit tests put unrelated data in the upper halves of the lanes, which exposes a sign taken from the wrong bit or an upper half that is not cleared. The scalar tests use a scalar that differs from every vector lane, so broadcast is clearly distinguished from pass-through. A NaN-payload scalar shows that only the sign bit changes. Integer operands are run with and without a modifier request to separate the error path from the normal path, and back-to-back and idle cycles check the one-cycle latency.

// File: rtl/opmod_pkg.sv
package opmod_pkg;

    localparam int ELEM_W = 64;
    localparam int HALF_W = ELEM_W / 2;

    typedef enum logic {
        WIDTH_32 = 1'b0,
        WIDTH_64 = 1'b1
    } elem_width_e;

    typedef struct packed {
        logic clear_sign;
        logic flip_sign;
    } sign_op_t;

    function automatic logic apply_sign(input logic s, input sign_op_t op);
        logic t;
        t = op.clear_sign ? 1'b0 : s;
        return t ^ op.flip_sign;
    endfunction

endpackage

// File: rtl/opmod_ctrl.sv
module opmod_ctrl
    import opmod_pkg::*;
(
    input  logic     mod_abs,
    input  logic     mod_neg,
    input  logic     type_int,
    output sign_op_t sign_op,
    output logic     type_err
);
    logic mod_req;

    always_comb begin
        mod_req            = mod_abs | mod_neg;
        type_err           = mod_req & type_int;
        sign_op.clear_sign = mod_abs & ~type_int;
        sign_op.flip_sign  = mod_neg & ~type_int;
    end
endmodule

// File: rtl/opmod_lane.sv
module opmod_lane
    import opmod_pkg::*;
(
    input  logic [ELEM_W-1:0] vec_word,
    input  logic [ELEM_W-1:0] scalar_word,
    input  logic              use_scalar,
    input  elem_width_e       width,
    input  sign_op_t          sign_op,
    output logic [ELEM_W-1:0] res_word
);
    logic [ELEM_W-1:0] picked;

    always_comb begin
        picked = use_scalar ? scalar_word : vec_word;
        unique case (width)
            WIDTH_64: res_word = {apply_sign(picked[ELEM_W-1], sign_op),
                                  picked[ELEM_W-2:0]};
            WIDTH_32: res_word = {{HALF_W{1'b0}},
                                  apply_sign(picked[HALF_W-1], sign_op),
                                  picked[HALF_W-2:0]};
            default:  res_word = '0;
        endcase
    end
endmodule

// File: rtl/opmod_stage.sv
module opmod_stage
    import opmod_pkg::*;
#(
    parameter int LANES   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*ELEM_W-1:0] src_vec,
    input  logic [ELEM_W-1:0]       src_scalar,
    input  logic                    scalar_sel,
    input  logic                    mod_abs,
    input  logic                    mod_neg,
    input  logic                    elem_wide,
    input  logic                    type_int,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_data,
    output logic                    out_err
);
    localparam int BUS_W = LANES * ELEM_W;

    sign_op_t          sign_op;
    logic              type_err;
    elem_width_e       width;
    logic [BUS_W-1:0]  lane_res;

    assign width = elem_wide ? WIDTH_64 : WIDTH_32;

    opmod_ctrl u_ctrl (
        .mod_abs  (mod_abs),
        .mod_neg  (mod_neg),
        .type_int (type_int),
        .sign_op  (sign_op),
        .type_err (type_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        opmod_lane u_lane (
            .vec_word    (src_vec[g*ELEM_W +: ELEM_W]),
            .scalar_word (src_scalar),
            .use_scalar  (scalar_sel),
            .width       (width),
            .sign_op     (sign_op),
            .res_word    (lane_res[g*ELEM_W +: ELEM_W])
        );
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_err   <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                out_err   <= in_valid & type_err;
                out_data  <= lane_res;
            end
        end

        p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        p_int_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && type_int && (mod_abs || mod_neg)) |=> out_err);
        p_fp_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !type_int) |=> !out_err);
        p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !elem_wide) |=> (out_data[ELEM_W-1:HALF_W] == '0));
        p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && scalar_sel) |=>
                (out_data[ELEM_W-1:0] == out_data[BUS_W-1 -: ELEM_W]));
        p_abs_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && elem_wide && mod_abs && mod_neg && !type_int) |=>
                out_data[ELEM_W-1]);
        p_payload_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && elem_wide) |=>
                (out_data[ELEM_W-2:0] ==
                 $past(scalar_sel ? src_scalar[ELEM_W-2:0] : src_vec[ELEM_W-2:0])));
    end else begin : g_comb
        always_comb begin
            out_valid = in_valid;
            out_err   = in_valid & type_err;
            out_data  = lane_res;
        end
    end
endmodule

// File: tb/tb_opmod_stage.sv
module tb_opmod_stage;
    localparam int  LANES = 64;
    localparam int  EW    = 64;
    localparam int  BW    = LANES * EW;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] src_vec = '0;
    logic [EW-1:0] src_scalar = '0;
    logic          scalar_sel = 1'b0;
    logic          mod_abs = 1'b0;
    logic          mod_neg = 1'b0;
    logic          elem_wide = 1'b1;
    logic          type_int = 1'b0;
    logic          out_valid;
    logic [BW-1:0] out_data;
    logic          out_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic [BW-1:0] exp_data_q[$];
    logic          exp_err_q[$];
    string         tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    opmod_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .src_scalar(src_scalar), .scalar_sel(scalar_sel), .mod_abs(mod_abs),
        .mod_neg(mod_neg), .elem_wide(elem_wide), .type_int(type_int),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [EW-1:0] model_lane(input logic [EW-1:0] v,
            input logic w, input logic a, input logic n, input logic i);
        logic ea, en, s;
        ea = a && !i;
        en = n && !i;
        if (w) begin
            s = v[63];
            if (ea) s = 1'b0;
            if (en) s = !s;
            return {s, v[62:0]};
        end
        s = v[31];
        if (ea) s = 1'b0;
        if (en) s = !s;
        return {32'h0, s, v[30:0]};
    endfunction

    function automatic logic [BW-1:0] make_vec(input logic [31:0] seed);
        logic [BW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            logic [31:0] hi, lo;
            hi = seed ^ (i * 32'h9E37_79B9);
            lo = ~seed + i;
            hi[31] = i[0];
            lo[31] = ~i[0];
            r[i*EW +: EW] = {hi, lo};
        end
        return r;
    endfunction

    task automatic apply(input logic [BW-1:0] v, input logic [EW-1:0] sc,
            input logic ssel, input logic a, input logic n, input logic w,
            input logic i, input string tag);
        logic [BW-1:0] e;
        @(negedge clk);
        src_vec = v; src_scalar = sc; scalar_sel = ssel;
        mod_abs = a; mod_neg = n; elem_wide = w; type_int = i;
        in_valid = 1'b1;
        for (int k = 0; k < LANES; k++)
            e[k*EW +: EW] = model_lane(ssel ? sc : v[k*EW +: EW], w, a, n, i);
        exp_data_q.push_back(e);
        exp_err_q.push_back(i && (a || n));
        tag_q.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_checks++;
            if (exp_data_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected out_valid, act=1 exp=0");
            end else begin
                logic [BW-1:0] e;
                logic ee;
                string t;
                e = exp_data_q.pop_front();
                ee = exp_err_q.pop_front();
                t = tag_q.pop_front();
                if (out_data !== e || out_err !== ee) begin
                    n_fail++;
                    $display("FAIL %s: lane0 act=%h exp=%h lane63 act=%h exp=%h err act=%b exp=%b",
                        t, out_data[63:0], e[63:0], out_data[BW-1 -: EW],
                        e[BW-1 -: EW], out_err, ee);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [BW-1:0] va, vb;
        va = make_vec(32'h1234_5678);
        vb = make_vec(32'hC0DE_F00D);
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: act=%b%b exp=00", out_valid, out_err);
        end
        rst_n = 1'b1;

        apply(va, 64'h0, 0, 0, 0, 1, 0, "R1 vector pass 64");
        apply(va, 64'h0, 0, 1, 0, 1, 0, "R3 abs 64");
        apply(vb, 64'h0, 0, 0, 1, 1, 0, "R4 neg 64");
        apply(vb, 64'h0, 0, 1, 1, 1, 0, "R5 abs+neg 64");
        apply(va, 64'h0, 0, 0, 1, 0, 0, "R6 neg 32");
        apply(vb, 64'h0, 0, 1, 1, 0, 0, "R6 abs+neg 32");
        apply(va, 64'h0, 0, 1, 0, 0, 0, "R3 abs 32");
        apply(va, 64'hBFF0_0000_0000_0001, 1, 0, 0, 1, 0, "R2 scalar bcast");
        apply(vb, 64'h5555_AAAA_C080_0001, 1, 1, 0, 0, 0, "R2 scalar abs 32");
        apply(va, 64'h7FF8_0000_0000_1234, 1, 0, 1, 1, 0, "R10 NaN payload neg");
        apply(vb, 64'h0, 0, 0, 1, 1, 1, "R7 int neg err");
        apply(va, 64'h0, 0, 1, 1, 0, 1, "R7 int abs+neg err 32");
        apply(vb, 64'h0, 0, 0, 0, 1, 1, "R8 int no mod");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        apply(vb, 64'h8000_0000_0000_0000, 1, 1, 0, 1, 0, "R9 after bubble");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || exp_data_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 idle: act=%b/%0d exp=0/0", out_valid, exp_data_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule